// File: doc/BRIEF.md
# Cache Way Allocation Mapper

This block decides which ways of a set-associative cache a process may use. A requester states how many ways it wants. The mapper answers with a mask that has one bit per physical way. Ordinary processes may share ways with each other. A process flagged as priority gets exclusive ways: those ways are locked, and no later grant contains them until they are freed. Each way keeps a small occupancy counter, and allocation spreads new processes onto the least occupied ways.

After a context switch, a process can ask the mapper to bring back the mask it saved earlier. The mapper keeps whichever saved ways are still unlocked. If none of them survive, it falls back to a fresh allocation of the requested size. When a process leaves a set of ways, a release command lowers their counters. A release marked as priority also unlocks those ways.

Allocation is a sequential scan that evaluates one way per clock. A done pulse marks the cycle in which the new mask becomes valid.

Top module: `way_alloc_mapper`

## Requirements
- R1: After reset `grantVec` is all zero, `done` and `busy` are low, every occupancy counter is zero and no way is locked.
- R2: A plain allocation grants min(`reqCount`, number of unlocked ways) distinct ways. Bit i of `grantVec` set means way i may be accessed. A request of zero yields an empty mask.
- R3: Ways granted with `isPriority`=1 are locked. They appear in no later grant, ordinary or restored, until a release with `releasePrio`=1 covers them.
- R4: Every way in a completed grant has its counter raised by one. The counter saturates at 2^CNT_W-1 and does not wrap.
- R5: Each allocated way is the unlocked, not yet chosen way with the smallest counter. Among equal counters, the lowest way index wins.
- R6: Ordinary grants may overlap: the same way can be handed to several non-priority processes.
- R7: With `restoreMode`=1, if `savedVec` & ~locks is nonzero, the grant is exactly that set. Counters and locks are then updated as for any grant.
- R8: With `restoreMode`=1 and every saved way locked (or `savedVec` zero), the mapper performs a plain allocation of `reqCount` ways.
- R9: A release (`releaseEn` while idle) lowers the counter of each way in `releaseVec` by one, stopping at zero. With `releasePrio`=1 it also clears the locks of those ways.
- R10: `busy` is high from the cycle after an accepted `start` until the grant completes. `done` is a one-cycle pulse, with `grantVec` valid and `busy` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an allocation; accepted only while idle |
| reqCount | input | $clog2(NUM_WAYS+1) | Number of ways requested |
| isPriority | input | 1 | Requester is a priority process; its ways get locked |
| restoreMode | input | 1 | Try to reinstate `savedVec` first |
| savedVec | input | NUM_WAYS | Mask saved at the last context switch |
| releaseEn | input | 1 | Release `releaseVec`; honoured only while idle |
| releaseVec | input | NUM_WAYS | Ways being given back |
| releasePrio | input | 1 | Released mask belonged to a priority process |
| grantVec | output | NUM_WAYS | Most recent granted way mask |
| done | output | 1 | One-cycle pulse when `grantVec` is updated |
| busy | output | 1 | Scan in progress |

## Verification
The hardest state to reach is counter saturation combined with tie breaking among locked and unlocked ways. Under random traffic, counters drift back down through releases. So a directed phase first locks all ways but one, then grants that single way far more often than the counter range allows. It then unlocks the others and lifts them to a nearby count, so that a wrapped counter would change which way is chosen. Random traffic then mixes priority grants, restores with random saved masks, oversized requests and releases of earlier grants. Every mask is compared against a bench model of counters and locks.

// File: rtl/wam_pkg.sv
package wam_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESTORE,
    ST_ALLOC,
    ST_COMMIT
  } wamState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAcc;       // new request accepted: clear accumulated mask
    logic evalRestore;  // restore scan step on current way
    logic evalAlloc;    // allocation scan step on current way
    logic passEnd;      // current way is the last of a pass
    logic commit;       // publish mask, bump counters, lock
    logic applyRelease; // apply release command
  } wamStrobe_t;

endpackage

// File: rtl/wam_ctrl.sv
module wam_ctrl
  import wam_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int REQ_W    = $clog2(NUM_WAYS + 1),
  parameter int IDX_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REQ_W-1:0] reqCount,
  input  logic             restoreMode,
  input  logic             releaseEn,
  input  logic             pickFound,
  input  logic             restoreHit,
  output wamStrobe_t       strb,
  output logic [IDX_W-1:0] wayIdx,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WAYS - 1);

  wamState_t        state;
  logic [REQ_W-1:0] reqLeft;
  logic             isIdle;

  assign isIdle = (state == ST_IDLE);
  assign busy   = !isIdle;

  always_comb begin
    strb              = '0;
    strb.clrAcc       = isIdle && start;
    strb.applyRelease = isIdle && releaseEn;
    strb.evalRestore  = (state == ST_RESTORE);
    strb.evalAlloc    = (state == ST_ALLOC) && (reqLeft != '0);
    strb.passEnd      = (wayIdx == LAST_IDX);
    strb.commit       = (state == ST_COMMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wayIdx  <= '0;
      reqLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            reqLeft <= reqCount;
            wayIdx  <= '0;
            state   <= restoreMode ? ST_RESTORE : ST_ALLOC;
          end
        end
        ST_RESTORE: begin
          if (wayIdx == LAST_IDX) begin
            wayIdx <= '0;
            state  <= restoreHit ? ST_COMMIT : ST_ALLOC;
          end else begin
            wayIdx <= wayIdx + 1'b1;
          end
        end
        ST_ALLOC: begin
          if (reqLeft == '0) begin
            state <= ST_COMMIT;
          end else if (wayIdx == LAST_IDX) begin
            wayIdx <= '0;
            if (pickFound) reqLeft <= reqLeft - 1'b1;
            else           state   <= ST_COMMIT;
          end else begin
            wayIdx <= wayIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an accepted start makes the block busy on the next cycle
  p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (isIdle && start) |=> busy);

  // R10: commit lasts one cycle and returns to idle
  p_commit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMMIT) |=> (state == ST_IDLE));

  // scan index stays within the way range
  p_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    wayIdx <= LAST_IDX);

endmodule

// File: rtl/wam_datapath.sv
module wam_datapath
  import wam_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int CNT_W    = 4,
  parameter int IDX_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wamStrobe_t          strb,
  input  logic [IDX_W-1:0]    wayIdx,
  input  logic                isPriority,
  input  logic [NUM_WAYS-1:0] savedVec,
  input  logic [NUM_WAYS-1:0] releaseVec,
  input  logic                releasePrio,
  output logic                pickFound,
  output logic                restoreHit,
  output logic [NUM_WAYS-1:0] grantVec,
  output logic                done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]    wayCnt [NUM_WAYS];
  logic [NUM_WAYS-1:0] lockVec;
  logic [NUM_WAYS-1:0] accVec;
  logic [NUM_WAYS-1:0] savedQ;
  logic                prioQ;
  logic                bestValid;
  logic [IDX_W-1:0]    bestIdx;
  logic [CNT_W-1:0]    bestCnt;

  logic                candidate;
  logic                better;
  logic                nextValid;
  logic [IDX_W-1:0]    nextIdx;
  logic                restoreBit;

  always_comb begin
    candidate  = !lockVec[wayIdx] && !accVec[wayIdx];
    better     = candidate && (!bestValid || (wayCnt[wayIdx] < bestCnt));
    nextValid  = bestValid || better;
    nextIdx    = better ? wayIdx : bestIdx;
    restoreBit = savedQ[wayIdx] && !lockVec[wayIdx];
    pickFound  = nextValid;
    restoreHit = (accVec != '0) || restoreBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lockVec   <= '0;
      accVec    <= '0;
      savedQ    <= '0;
      prioQ     <= 1'b0;
      bestValid <= 1'b0;
      bestIdx   <= '0;
      bestCnt   <= '0;
      grantVec  <= '0;
      done      <= 1'b0;
    end else begin
      done <= strb.commit;
      if (strb.clrAcc) begin
        accVec    <= '0;
        bestValid <= 1'b0;
        prioQ     <= isPriority;
        savedQ    <= savedVec;
      end
      if (strb.evalRestore && restoreBit) accVec[wayIdx] <= 1'b1;
      if (strb.evalAlloc) begin
        if (strb.passEnd) begin
          bestValid <= 1'b0;
          if (nextValid) accVec[nextIdx] <= 1'b1;
        end else begin
          bestValid <= nextValid;
          bestIdx   <= nextIdx;
          if (better) bestCnt <= wayCnt[wayIdx];
        end
      end
      if (strb.commit) begin
        grantVec <= accVec;
        if (prioQ) lockVec <= lockVec | accVec;
      end
      if (strb.applyRelease && releasePrio) lockVec <= lockVec & ~releaseVec;
    end
  end

  for (genvar g = 0; g < NUM_WAYS; g++) begin : gWay
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wayCnt[g] <= '0;
      end else if (strb.commit && accVec[g]) begin
        if (wayCnt[g] != CNT_MAX) wayCnt[g] <= wayCnt[g] + 1'b1;
      end else if (strb.applyRelease && releaseVec[g]) begin
        if (wayCnt[g] != '0) wayCnt[g] <= wayCnt[g] - 1'b1;
      end
    end

    // R4: a saturated counter holds its value on a further grant
    p_cnt_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.commit && accVec[g] && (wayCnt[g] == CNT_MAX)) |=> (wayCnt[g] == CNT_MAX));

    // R9: a release lowers a nonzero counter by exactly one
    p_release_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.applyRelease && releaseVec[g] && (wayCnt[g] != '0))
        |=> (wayCnt[g] == $past(wayCnt[g]) - 1'b1));
  end

  // R3: a published mask never contains a way locked before that commit
  p_lock_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((grantVec & $past(lockVec)) == '0));

  // R3: new locks appear only through a priority commit
  p_lock_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.commit && prioQ) |=> ((lockVec & ~$past(lockVec)) == '0));

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/way_alloc_mapper.sv
module way_alloc_mapper
  import wam_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int CNT_W    = 4,
  localparam int REQ_W   = $clog2(NUM_WAYS + 1),
  localparam int IDX_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [REQ_W-1:0]    reqCount,
  input  logic                isPriority,
  input  logic                restoreMode,
  input  logic [NUM_WAYS-1:0] savedVec,
  input  logic                releaseEn,
  input  logic [NUM_WAYS-1:0] releaseVec,
  input  logic                releasePrio,
  output logic [NUM_WAYS-1:0] grantVec,
  output logic                done,
  output logic                busy
);

  wamStrobe_t       strb;
  logic [IDX_W-1:0] wayIdx;
  logic             pickFound;
  logic             restoreHit;

  wam_ctrl #(.NUM_WAYS(NUM_WAYS), .REQ_W(REQ_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .start(start), .reqCount(reqCount),
    .restoreMode(restoreMode), .releaseEn(releaseEn),
    .pickFound(pickFound), .restoreHit(restoreHit),
    .strb(strb), .wayIdx(wayIdx), .busy(busy)
  );

  wam_datapath #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wayIdx(wayIdx),
    .isPriority(isPriority), .savedVec(savedVec),
    .releaseVec(releaseVec), .releasePrio(releasePrio),
    .pickFound(pickFound), .restoreHit(restoreHit),
    .grantVec(grantVec), .done(done)
  );

endmodule

// File: tb/tb_way_alloc_mapper.sv
module tb_way_alloc_mapper;

  localparam int NW    = 8;
  localparam int CW    = 4;
  localparam int CMAX  = (1 << CW) - 1;
  localparam int REQW  = $clog2(NW + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [REQW-1:0] reqCount = '0;
  logic            isPriority = 1'b0;
  logic            restoreMode = 1'b0;
  logic [NW-1:0]   savedVec = '0;
  logic            releaseEn = 1'b0;
  logic [NW-1:0]   releaseVec = '0;
  logic            releasePrio = 1'b0;
  logic [NW-1:0]   grantVec;
  logic            done;
  logic            busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int            mCnt [NW];
  logic [NW-1:0] mLock;

  logic [NW-1:0] hVec  [64];
  bit            hPrio [64];
  int            hN = 0;

  always #10 clk = ~clk;

  way_alloc_mapper #(.NUM_WAYS(NW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .reqCount(reqCount),
    .isPriority(isPriority), .restoreMode(restoreMode), .savedVec(savedVec),
    .releaseEn(releaseEn), .releaseVec(releaseVec), .releasePrio(releasePrio),
    .grantVec(grantVec), .done(done), .busy(busy)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] modelAlloc(int req);
    logic [NW-1:0] v = '0;
    for (int k = 0; k < req; k++) begin
      int best = -1;
      for (int i = 0; i < NW; i++)
        if (!mLock[i] && !v[i] && (best < 0 || mCnt[i] < mCnt[best])) best = i;
      if (best < 0) break;
      v[best] = 1'b1;
    end
    return v;
  endfunction

  task automatic doAlloc(int req, bit prio, bit rest, logic [NW-1:0] saved, string tag);
    logic [NW-1:0] keep = saved & ~mLock;
    logic [NW-1:0] expV;
    int waitCnt = 0;
    expV = (rest && keep != '0) ? keep : modelAlloc(req);
    @(negedge clk);
    start = 1'b1; reqCount = REQW'(req); isPriority = prio;
    restoreMode = rest; savedVec = saved;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    while (!done && waitCnt < 1000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(grantVec == expV, tag, int'(grantVec), int'(expV));
    chk(busy == 1'b0, "R10 idle with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    for (int i = 0; i < NW; i++)
      if (expV[i] && mCnt[i] < CMAX) mCnt[i]++;
    if (prio) mLock |= expV;
    if (hN < 64) begin
      hVec[hN] = expV; hPrio[hN] = prio; hN++;
    end
  endtask

  task automatic doRelease(logic [NW-1:0] v, bit prio);
    @(negedge clk);
    releaseEn = 1'b1; releaseVec = v; releasePrio = prio;
    @(negedge clk);
    releaseEn = 1'b0;
    for (int i = 0; i < NW; i++)
      if (v[i] && mCnt[i] > 0) mCnt[i]--;
    if (prio) mLock &= ~v;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NW; i++) mCnt[i] = 0;
    mLock = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(grantVec == '0, "R1 grant reset", int'(grantVec), 0);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);

    // R1/R5: fresh counters, lowest indices first
    doAlloc(3, 0, 0, '0, "R1 R5 first grant");
    chk(grantVec == 8'h07, "R5 lowest index tie", int'(grantVec), 8'h07);
    doAlloc(3, 0, 0, '0, "R5 least used ways");
    chk(grantVec == 8'h38, "R5 least used ways const", int'(grantVec), 8'h38);
    doAlloc(8, 0, 0, '0, "R6 shared full grant");
    doAlloc(2, 0, 0, '0, "R5 balance");
    doAlloc(0, 0, 0, '0, "R2 empty request");
    // R3: priority lock and shortened grant
    doAlloc(2, 1, 0, '0, "R3 priority grant");
    doAlloc(8, 0, 0, '0, "R2 R3 fewer than requested");
    // R7, R8
    doAlloc(1, 0, 1, 8'h0F, "R7 restore keeps unlocked");
    doAlloc(2, 0, 1, hVec[5], "R8 restore fallback");
    doAlloc(3, 0, 1, 8'h00, "R8 restore empty saved");
    // R9: priority release unlocks
    doRelease(hVec[5], 1);
    doAlloc(8, 0, 0, '0, "R9 unlocked after release");

    // R4 saturation corner
    doAlloc(7, 1, 0, '0, "R3 lock seven ways");
    for (int k = 0; k < 20; k++) doAlloc(1, 0, 0, '0, "R4 single way repeat");
    doRelease(hVec[hN-21], 1);
    doRelease(8'h80, 0);
    for (int k = 0; k < 12; k++) doAlloc(7, 0, 0, '0, "R4 R5 after saturation");
    doAlloc(2, 0, 0, '0, "R4 saturated tie");
    doRelease(8'hFF, 0);
    doAlloc(3, 0, 0, '0, "R9 R5 after release");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 3 && hN > 0) begin
        int j = $urandom_range(0, hN - 1);
        doRelease(hVec[j], hPrio[j]);
        hVec[j] = hVec[hN-1]; hPrio[j] = hPrio[hN-1]; hN--;
      end else begin
        bit p = ($urandom_range(0, 7) == 0);
        bit r = ($urandom_range(0, 3) == 0);
        logic [NW-1:0] s = NW'($urandom);
        int q = $urandom_range(0, 8);
        doAlloc(q, p, r, s, r ? "R7 R8 random restore" : "R2 R5 random alloc");
      end
    end
    finishRun();
  end

endmodule